// File: doc/BRIEF.md
# Quad-Buffered Packet FIFO

This block holds an outgoing byte stream in four equal packet buffers that are used in strict rotation. A writer pushes bytes one per clock through a valid/ready port. Once the buffer it is filling reaches 512 bytes, the block hands that buffer to the drain side without being asked and moves the writer on to the next buffer. A flush input closes a partly filled buffer early, so short packets can also be sent.

The drain side reads the committed buffers out one byte at a time, oldest first, through a valid/ready port. It marks the final byte of each packet. A buffer goes back to the writer only after its last byte has been taken. When the writer catches up with a buffer that has not yet been drained, its ready flag drops. That flag stays low until the drain frees the buffer. Everything runs on one clock with a synchronous active-high reset.

Top module: `qbuf_pkt_fifo`

## Requirements
- R1: Storage is four buffers of 512 bytes (2048 bytes in all). Bytes leave the drain port in exactly the order they were accepted, and no packet is longer than 512 bytes.
- R2: The 512th byte accepted into a buffer commits that buffer with no flush. If the drain side was idle, rd_valid is high in the cycle after the edge that took that byte, and low before it.
- R3: Buffers fill in the rotation 0,1,2,3,0 and drain in the same rotation, so packets leave in the order they were committed.
- R4: When all four buffers are committed and undrained, wr_ready is low and bytes offered on the write port are not taken. wr_ready rises in the cycle after the edge that takes the final byte of the oldest packet.
- R5: A buffer is freed only by the transfer of its final byte, so wr_ready stays low while that byte is still pending. A committed buffer is never written.
- R6: A flush pulse with wr_ready high commits the current buffer with the number of bytes it holds, and a byte accepted in the same cycle is counted. A flush is ignored when the current buffer is empty and no byte is accepted with it, or when wr_ready is low.
- R7: rd_last is high only on the final byte of a packet. While rd_valid is high and rd_ready is low, rd_valid, rd_data and rd_last hold their values.
- R8: After reset all buffers are free and both rotation pointers are at buffer 0, so wr_ready is 1 and rd_valid is 0. A byte moves on a rising edge where valid and ready are both high on its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Writer offers a byte |
| wr_data | input | 8 | Byte offered by the writer |
| flush | input | 1 | Commit the partly filled current buffer |
| wr_ready | output | 1 | Current write buffer is free to take bytes |
| rd_ready | input | 1 | Drain side accepts a byte |
| rd_valid | output | 1 | A committed byte is presented |
| rd_data | output | 8 | Presented byte |
| rd_last | output | 1 | Presented byte is the final byte of its packet |

## Verification
The hardest state to reach is the full condition: all four buffers are committed and the writer is stalled on the oldest one. Reaching it needs 2048 bytes written while the drain is held off. The stimulus then offers extra bytes and a flush that must both be ignored. Next it releases the drain and watches wr_ready cycle by cycle around the final byte of the oldest packet. After that, a throttled drain pattern runs against continuous writes, so that commits, frees and stalls overlap. A scoreboard queue of expected bytes and end-of-packet flags checks every byte that leaves the block.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
    localparam int QB_DATA_W    = 8;
    localparam int QB_NUM_BUFS  = 4;
    localparam int QB_BUF_BYTES = 512;
    localparam int QB_IDX_W     = $clog2(QB_NUM_BUFS);
    localparam int QB_PTR_W     = $clog2(QB_BUF_BYTES);
    localparam int QB_LEN_W     = $clog2(QB_BUF_BYTES + 1);
    localparam int QB_ADDR_W    = QB_IDX_W + QB_PTR_W;
    localparam int QB_TOTAL     = QB_NUM_BUFS * QB_BUF_BYTES;

    typedef logic [QB_DATA_W-1:0] qb_byte_t;
    typedef logic [QB_IDX_W-1:0]  qb_idx_t;
    typedef logic [QB_PTR_W-1:0]  qb_ptr_t;
    typedef logic [QB_LEN_W-1:0]  qb_len_t;
    typedef logic [QB_ADDR_W-1:0] qb_addr_t;

    typedef enum logic {
        BUF_OPEN  = 1'b0,
        BUF_READY = 1'b1
    } qb_state_t;

    typedef struct packed {
        qb_state_t state;
        qb_len_t   len;
    } qb_desc_t;

    typedef struct packed {
        logic    valid;
        qb_idx_t idx;
        qb_len_t len;
    } qb_commit_t;

    function automatic qb_idx_t qb_next_idx(input qb_idx_t cur);
        if (cur == qb_idx_t'(QB_NUM_BUFS - 1)) begin
            return '0;
        end
        return cur + qb_idx_t'(1);
    endfunction
endpackage

// File: rtl/qbuf_mem.sv
module qbuf_mem
    import qbuf_pkg::*;
(
    input  logic     clk,
    input  logic     we,
    input  qb_addr_t waddr,
    input  qb_byte_t wdata,
    input  qb_addr_t raddr,
    output qb_byte_t rdata
);
    qb_byte_t store [QB_TOTAL];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/qbuf_writer.sv
module qbuf_writer
    import qbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  qb_byte_t   wr_data,
    input  logic       flush,
    input  logic       cur_busy,
    output logic       wr_ready,
    output qb_idx_t    wr_idx,
    output qb_commit_t commit,
    output logic       mem_we,
    output qb_addr_t   mem_addr,
    output qb_byte_t   mem_data
);
    qb_ptr_t fill_ptr;
    logic    accept;
    logic    fill_end;
    logic    flush_take;

    assign wr_ready   = !cur_busy;
    assign accept     = wr_valid && wr_ready;
    assign fill_end   = accept && (fill_ptr == qb_ptr_t'(QB_BUF_BYTES - 1));
    assign flush_take = flush && wr_ready && !fill_end && (accept || fill_ptr != '0);

    always_comb begin
        commit.valid = fill_end || flush_take;
        commit.idx   = wr_idx;
        commit.len   = qb_len_t'(fill_ptr) + qb_len_t'(accept);
    end

    assign mem_we   = accept;
    assign mem_addr = {wr_idx, fill_ptr};
    assign mem_data = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx   <= '0;
            fill_ptr <= '0;
        end else if (commit.valid) begin
            wr_idx   <= qb_next_idx(wr_idx);
            fill_ptr <= '0;
        end else if (accept) begin
            fill_ptr <= fill_ptr + qb_ptr_t'(1);
        end
    end

    AST_ROTATE_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit.valid |=> wr_idx == qb_next_idx($past(wr_idx))); // R3
endmodule

// File: rtl/qbuf_drain.sv
module qbuf_drain
    import qbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_ready,
    input  logic     cur_ready,
    input  qb_len_t  cur_len,
    output logic     rd_valid,
    output logic     rd_last,
    output qb_idx_t  rd_idx,
    output qb_addr_t mem_addr,
    output logic     free_valid
);
    qb_ptr_t drain_ptr;
    logic    take;

    assign rd_valid   = cur_ready;
    assign rd_last    = cur_ready && ((qb_len_t'(drain_ptr) + qb_len_t'(1)) == cur_len);
    assign take       = rd_valid && rd_ready;
    assign free_valid = take && rd_last;
    assign mem_addr   = {rd_idx, drain_ptr};

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx    <= '0;
            drain_ptr <= '0;
        end else if (free_valid) begin
            rd_idx    <= qb_next_idx(rd_idx);
            drain_ptr <= '0;
        end else if (take) begin
            drain_ptr <= drain_ptr + qb_ptr_t'(1);
        end
    end
endmodule

// File: rtl/qbuf_pkt_fifo.sv
module qbuf_pkt_fifo
    import qbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       flush,
    output logic       wr_ready,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_last
);
    qb_desc_t               desc [QB_NUM_BUFS];
    logic [QB_NUM_BUFS-1:0] ready_vec;
    qb_commit_t             commit;
    qb_idx_t                wr_idx;
    qb_idx_t                rd_idx;
    logic                   free_valid;
    logic                   mem_we;
    qb_addr_t               mem_waddr;
    qb_addr_t               mem_raddr;
    qb_byte_t               mem_wdata;

    for (genvar g = 0; g < QB_NUM_BUFS; g++) begin : g_desc
        always_ff @(posedge clk) begin
            if (rst) begin
                desc[g].state <= BUF_OPEN;
                desc[g].len   <= '0;
            end else if (commit.valid && commit.idx == qb_idx_t'(g)) begin
                desc[g].state <= BUF_READY;
                desc[g].len   <= commit.len;
            end else if (free_valid && rd_idx == qb_idx_t'(g)) begin
                desc[g].state <= BUF_OPEN;
            end
        end
        assign ready_vec[g] = (desc[g].state == BUF_READY);
    end

    qbuf_writer u_writer (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .flush    (flush),
        .cur_busy (ready_vec[wr_idx]),
        .wr_ready (wr_ready),
        .wr_idx   (wr_idx),
        .commit   (commit),
        .mem_we   (mem_we),
        .mem_addr (mem_waddr),
        .mem_data (mem_wdata)
    );

    qbuf_drain u_drain (
        .clk        (clk),
        .rst        (rst),
        .rd_ready   (rd_ready),
        .cur_ready  (ready_vec[rd_idx]),
        .cur_len    (desc[rd_idx].len),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .rd_idx     (rd_idx),
        .mem_addr   (mem_raddr),
        .free_valid (free_valid)
    );

    qbuf_mem u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> ready_vec == '1); // R4
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        commit.valid |-> desc[commit.idx].state == BUF_OPEN); // R5
    AST_NONEMPTY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit.valid |-> commit.len != '0); // R6
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last))); // R7
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wr_ready && !rd_valid)); // R8
endmodule

// File: tb/qbuf_pkt_fifo_tb.sv
module qbuf_pkt_fifo_tb;
    import qbuf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PKT        = QB_BUF_BYTES;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flush = 1'b0;
    logic       wr_ready;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_last;

    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    int         rd_mode = 0;
    int         cyc = 0;
    int         fill_cnt = 0;
    int         seq = 0;
    logic [7:0] exp_data_q [$];
    bit         exp_last_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    qbuf_pkt_fifo u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .flush(flush),
        .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic mark_last();
        exp_last_q[exp_last_q.size()-1] = 1'b1;
        fill_cnt = 0;
    endtask

    task automatic drive_byte(input bit fl);
        logic [7:0] d;
        @(posedge clk); #1;
        d = seq[7:0] ^ seq[15:8] ^ 8'h5A;
        wr_valid = 1'b1;
        wr_data  = d;
        flush    = fl;
        if (wr_ready) begin
            exp_data_q.push_back(d);
            exp_last_q.push_back(1'b0);
            seq++;
            fill_cnt++;
            if (fill_cnt == PKT || fl) mark_last();
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        wr_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic flush_only();
        @(posedge clk); #1;
        wr_valid = 1'b0;
        flush    = 1'b1;
        if (wr_ready && fill_cnt > 0) mark_last();
    endtask

    task automatic wait_drained();
        while (exp_data_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R6", "no extra packet after drain, rd_valid", rd_valid, 0);
    endtask

    // drain-side ready driver
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (rd_mode)
            0:       rd_ready = 1'b0;
            1:       rd_ready = 1'b1;
            default: rd_ready = (cyc % 3) != 0;
        endcase
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid && rd_ready) begin
            if (exp_data_q.size() == 0) begin
                check(1'b0, "R1", "unexpected byte on drain port", rd_data, -1);
            end else begin
                logic [7:0] ed;
                bit         el;
                ed = exp_data_q.pop_front();
                el = exp_last_q.pop_front();
                check(rd_data == ed, "R1 R3", "drain byte order", rd_data, ed);
                check(rd_last == el, "R7", "end-of-packet flag", rd_last, el);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(wr_ready == 1'b1, "R8", "wr_ready after reset", wr_ready, 1);
        check(rd_valid == 1'b0, "R8", "rd_valid after reset", rd_valid, 0);

        // first packet fills with drain held off
        for (int i = 0; i < PKT; i++) drive_byte(1'b0);
        @(negedge clk);
        check(rd_valid == 1'b0, "R2", "rd_valid before 512th byte taken", rd_valid, 0);
        idle();
        @(negedge clk);
        check(rd_valid == 1'b1, "R2", "rd_valid after auto commit", rd_valid, 1);
        check(rd_last == 1'b0, "R7", "rd_last on first byte", rd_last, 0);
        check(rd_data == exp_data_q[0], "R1", "first presented byte", rd_data, exp_data_q[0]);
        held = rd_data;
        @(negedge clk);
        check(rd_valid == 1'b1 && rd_data == held, "R7", "held byte under stall", rd_data, held);

        // fill the remaining three buffers
        for (int i = 0; i < 3*PKT; i++) drive_byte(1'b0);
        idle();
        @(negedge clk);
        check(wr_ready == 1'b0, "R4", "wr_ready with all buffers committed", wr_ready, 0);
        repeat (5) drive_byte(1'b0);
        flush_only();
        idle();
        @(negedge clk);
        check(wr_ready == 1'b0, "R4", "wr_ready still low after blocked writes", wr_ready, 0);
        check(exp_data_q.size() == 4*PKT, "R4", "bytes accepted while full", exp_data_q.size(), 4*PKT);

        // release drain, watch the oldest buffer return
        rd_mode = 1;
        @(negedge clk);
        while (!(rd_valid && rd_ready && rd_last)) @(negedge clk);
        check(wr_ready == 1'b0, "R5", "wr_ready while final byte pending", wr_ready, 0);
        @(negedge clk);
        check(wr_ready == 1'b1, "R4", "wr_ready after oldest packet drained", wr_ready, 1);
        wait_drained();

        // short packets through flush
        for (int i = 0; i < 5; i++) drive_byte(1'b0);
        flush_only();
        idle();
        for (int i = 0; i < 6; i++) drive_byte(1'b0);
        drive_byte(1'b1);
        idle();
        flush_only();
        idle();
        wait_drained();

        // throttled drain against continuous writes
        rd_mode = 2;
        for (int i = 0; i < 600; i++) drive_byte(1'b0);
        flush_only();
        drive_byte(1'b1);
        idle();
        wait_drained();
        for (int i = 0; i < 4*PKT + 100; i++) drive_byte(1'b0);
        flush_only();
        idle();
        wait_drained();
        check(exp_data_q.size() == 0, "R3", "all packets drained in order", exp_data_q.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule